// File: doc/BRIEF.md
# Guarded-Enable Interval Timer

A 16-bit up-counter with three registers on a simple synchronous register port: mode/control, compare limit and count. A write takes effect at the clock edge where `wr_en` is high. The read port is combinational on `addr`. While counting is switched on, the count rises by one each clock. When it equals the compare limit, the block sets a sticky flag, raises `irq` in that cycle if interrupts are allowed, and then either wraps to zero (repeat mode) or switches itself off and holds the count (one-shot mode).

The run bit is protected against accidental changes. A control write changes it only when the same write data also carries a qualifier bit. That qualifier is never stored. The other control fields take every control write. There is no back-pressure anywhere: every write is accepted in its cycle, and the read data is valid in the same cycle as the address.

Top module: `gtm_timer`

## Requirements
- R1: After reset the control register reads 0x0000, the count reads 0x0000, the compare limit reads 0xFFFF and `irq` is low.
- R2: Addresses: 0 is control, 1 is the compare limit, 2 is the count, and 3 reads 0x0000 and ignores writes. The compare limit is a full 16-bit read/write value.
- R3: While the run bit (control bit 15) is 1 and the count differs from the limit, the count increments each clock. While the run bit is 0 the count holds.
- R4: A control write changes the run bit to write-data bit 15 only if write-data bit 14 is 1. Otherwise the run bit keeps its value, while the interrupt-allow bit (13), the repeat bit (0) and the flag clear still apply.
- R5: Control bit 14 and all bits other than 15, 13, 5 and 0 read as 0.
- R6: The flag (control bit 5) is set on every clock edge where count equals limit, whatever the run bit. It stays set until a control write with bit 5 = 0 clears it. A set in the same cycle wins over the clear, and writing bit 5 = 1 does not set it.
- R7: With repeat = 1, a running count that equals the limit goes to 0 on the next clock.
- R8: With repeat = 0, a running count that equals the limit makes hardware clear the run bit, and the count stays at the limit.
- R9: `irq` is high exactly in cycles where the run bit is 1, interrupt-allow (bit 13) is 1 and the count equals the limit. It is never high while interrupt-allow is 0.
- R10: A write to address 2 loads the count directly and takes priority over counting.
- R11: A qualified control write to the run bit wins over a hardware one-shot clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled at the clock edge |
| addr | input | 2 | Register select for reads and writes |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request, high in the matching cycle |

## Verification
The bench chases collisions. A flag clear written on the very cycle of a match must lose, or the flag would drop with a match just seen. A qualified re-enable on the cycle a one-shot would stop must win, or the timer would stall after software asked it to run. It also checks a compare limit of zero in repeat mode, where the count sits at 0 and `irq` stays high. It checks unqualified enable writes, which a naive design would honour by starting the count. Finally, it checks a match while stopped, which must still set the flag; a design that gated the flag with the run bit would leave it clear.

// File: rtl/gtm_pkg.sv
package gtm_pkg;
  localparam int DW = 16;

  typedef enum logic [1:0] {
    RA_CTRL  = 2'd0,
    RA_LIMIT = 2'd1,
    RA_COUNT = 2'd2,
    RA_NONE  = 2'd3
  } gtm_addr_e;

  localparam int B_RUN    = 15;
  localparam int B_QUAL   = 14;
  localparam int B_IE     = 13;
  localparam int B_FLAG   = 5;
  localparam int B_REPEAT = 0;
endpackage

// File: rtl/gtm_ctrl.sv
module gtm_ctrl
  import gtm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic [DW-1:0] wdata,
  input  logic          match,
  output logic          run,
  output logic          ie,
  output logic          rpt,
  output logic          flag,
  output logic          irq
);
  logic stop_hw;
  logic qual_wr;

  assign stop_hw = run & match & ~rpt;
  assign qual_wr = wr_ctrl & wdata[B_QUAL];
  assign irq     = run & ie & match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      ie   <= 1'b0;
      rpt  <= 1'b0;
      flag <= 1'b0;
    end else begin
      if (qual_wr)      run <= wdata[B_RUN];
      else if (stop_hw) run <= 1'b0;
      if (wr_ctrl) begin
        ie  <= wdata[B_IE];
        rpt <= wdata[B_REPEAT];
      end
      if (match)                          flag <= 1'b1;
      else if (wr_ctrl && !wdata[B_FLAG]) flag <= 1'b0;
    end
  end

  AST_RUN_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
    (run != $past(run)) |-> ($past(qual_wr) || ($past(stop_hw) && !run))); // R4
  AST_FLAG_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> flag); // R6
  AST_SHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_hw && !qual_wr) |=> !run); // R8
  AST_QUAL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_hw && qual_wr && wdata[B_RUN]) |=> run); // R11
endmodule

// File: rtl/gtm_counter.sv
module gtm_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         rpt,
  input  logic         wr_limit,
  input  logic         wr_count,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] count,
  output logic [W-1:0] limit,
  output logic         match
);
  localparam logic [W-1:0] LIMIT_RST = {W{1'b1}};

  assign match = (count == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) limit <= LIMIT_RST;
    else if (wr_limit) limit <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (wr_count) begin
      count <= wdata;
    end else if (run) begin
      if (!match)  count <= count + 1'b1;
      else if (rpt) count <= '0;
    end
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_count) |=> $stable(count)); // R3
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && match && rpt && !wr_count) |=> (count == '0)); // R7
  AST_SHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && match && !rpt && !wr_count) |=> $stable(count)); // R8
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_count |=> (count == $past(wdata))); // R10
  AST_LIMIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_limit |=> (limit == $past(wdata))); // R2
endmodule

// File: rtl/gtm_timer.sv
module gtm_timer
  import gtm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  gtm_addr_e sel;
  logic wr_ctrl, wr_limit, wr_count;
  logic run, ie, rpt, flag, match;
  logic [DW-1:0] count, limit, ctrl_view;

  assign sel      = gtm_addr_e'(addr);
  assign wr_ctrl  = wr_en && (sel == RA_CTRL);
  assign wr_limit = wr_en && (sel == RA_LIMIT);
  assign wr_count = wr_en && (sel == RA_COUNT);

  gtm_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wdata(wdata), .match(match),
    .run(run), .ie(ie), .rpt(rpt), .flag(flag), .irq(irq)
  );

  gtm_counter #(.W(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .rpt(rpt), .wr_limit(wr_limit),
    .wr_count(wr_count), .wdata(wdata), .count(count), .limit(limit), .match(match)
  );

  always_comb begin
    ctrl_view           = '0;
    ctrl_view[B_RUN]    = run;
    ctrl_view[B_IE]     = ie;
    ctrl_view[B_FLAG]   = flag;
    ctrl_view[B_REPEAT] = rpt;
  end

  always_comb begin
    unique case (sel)
      RA_CTRL:  rdata = ctrl_view;
      RA_LIMIT: rdata = limit;
      RA_COUNT: rdata = count;
      default:  rdata = '0;
    endcase
  end

  AST_IRQ_NOT_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie && !$past(wr_ctrl)) |-> !irq); // R9
endmodule

// File: tb/gtm_timer_test.sv
module gtm_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_run = 0, m_ie = 0, m_rpt = 0, m_flag = 0;
  int m_cnt = 0, m_lim = 16'hFFFF;

  always #5 clk = ~clk;

  gtm_timer uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                 .wdata(wdata), .rdata(rdata), .irq(irq));

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input bit wr, input int a, input int d, input string req);
    int exp_rd, exp_irq, mt, stop, nd;
    wr_en = wr; addr = a[1:0]; wdata = d[15:0];
    #1;
    mt = (m_cnt == m_lim);
    case (a)
      0: exp_rd = (m_run << 15) | (m_ie << 13) | (m_flag << 5) | m_rpt;
      1: exp_rd = m_lim;
      2: exp_rd = m_cnt;
      default: exp_rd = 0;
    endcase
    exp_irq = (m_run && m_ie && mt) ? 1 : 0;
    check(req, "rdata", int'(rdata), exp_rd);
    check((req == "R1") ? "R1" : "R9", "irq", int'(irq), exp_irq);
    @(posedge clk);
    stop = m_run && mt && !m_rpt;
    nd = d & 16'hFFFF;
    if (wr && a == 2) m_cnt = nd;
    else if (m_run) begin
      if (!mt) m_cnt = (m_cnt + 1) & 16'hFFFF;
      else if (m_rpt) m_cnt = 0;
    end
    if (wr && a == 1) m_lim = nd;
    if (wr && a == 0 && nd[14]) m_run = nd[15];
    else if (stop) m_run = 0;
    if (mt) m_flag = 1;
    else if (wr && a == 0 && !nd[5]) m_flag = 0;
    if (wr && a == 0) begin
      m_ie = nd[13];
      m_rpt = nd[0];
    end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    cyc(0, 0, 0, "R1"); cyc(0, 1, 0, "R1"); cyc(0, 2, 0, "R1");
    // R2 map, full-width limit, unused address
    cyc(1, 1, 16'hA5C3, "R2"); cyc(0, 1, 0, "R2");
    cyc(1, 3, 16'h1234, "R2"); cyc(0, 3, 0, "R2");
    cyc(1, 1, 16'h0005, "R2");
    // R4 unqualified enable ignored, other fields land; R3 hold
    cyc(1, 0, 16'hA001, "R4");
    for (int i = 0; i < 4; i++) cyc(0, 2, 0, "R3");
    cyc(0, 0, 0, "R4");
    // R5 qualifier and reserved bits read zero
    cyc(1, 0, 16'h5FDE, "R5"); cyc(0, 0, 0, "R5");
    cyc(1, 0, 16'h4000, "R5");
    // R7/R9 repeat mode with interrupts
    cyc(1, 0, 16'hE001, "R7");
    for (int i = 0; i < 14; i++) cyc(0, 2, 0, "R7");
    cyc(0, 0, 0, "R6");
    // R6 clears on every cycle, colliding with matches
    for (int i = 0; i < 14; i++) cyc(1, 0, 16'h2001, "R6");
    cyc(1, 0, 16'h2021, "R6"); cyc(0, 0, 0, "R6");
    // R10 load while running
    cyc(1, 2, 16'h0003, "R10");
    for (int i = 0; i < 4; i++) cyc(0, 2, 0, "R10");
    // R8 one-shot
    cyc(1, 2, 0, "R10");
    cyc(1, 0, 16'hE000, "R8");
    for (int i = 0; i < 9; i++) cyc(0, 2, 0, "R8");
    cyc(0, 0, 0, "R8");
    // R11 qualified re-enable on the stop cycle
    cyc(1, 0, 16'hC000, "R11"); cyc(1, 0, 16'hC000, "R11");
    cyc(0, 0, 0, "R11"); cyc(0, 2, 0, "R11");
    // R6 flag sets while stopped
    cyc(1, 0, 16'h4000, "R6"); cyc(1, 2, 0, "R6");
    cyc(1, 0, 16'h4000, "R6"); cyc(0, 0, 0, "R6");
    cyc(1, 2, 16'h0005, "R6"); cyc(0, 0, 0, "R6"); cyc(0, 2, 0, "R6");
    // R9 no irq with interrupts off
    cyc(1, 2, 0, "R9"); cyc(1, 0, 16'hC001, "R9");
    for (int i = 0; i < 12; i++) cyc(0, 2, 0, "R9");
    // limit zero in repeat mode with interrupts
    cyc(1, 1, 0, "R7"); cyc(1, 2, 0, "R7"); cyc(1, 0, 16'hE001, "R7");
    for (int i = 0; i < 4; i++) cyc(0, 2, 0, "R9");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule